// File: doc/BRIEF.md
# Per-Rank DRAM Activity Power Estimator

This block keeps a running estimate of the activity-based power drawn by each of four DRAM ranks. Every clock, each rank is given an input value built from three parts. The first is an idle weight picked from the rank's state: open pages, precharged and awake, or precharged and powered down. The second is a command weight, added when a command is sent to that rank. The third is a termination weight, added while on-die termination is active on that rank. Each rank has its own exponential moving-average filter that smooths these values. A registered throttle flag for each rank rises while the smoothed value is at or above a programmable limit.

All seven weights and the limit are loaded through a simple write port. A sticky lock bit protects the weights from further change until the next reset. Memory-controller logic uses the throttle flags to decide when a rank should be slowed down.

Top module: `rank_power_filter`

## Requirements
- R1: A reset clears all seven weights, the threshold, the lock bit, every accumulator, every `avg_out` field and every `throttle` bit to zero. After reset, weight writes are accepted again.
- R2: Each rank's idle weight for a clock is chosen as follows. When `power_down` is 1, the precharged-power-down weight (address 2) is used, whatever the page state. Otherwise, when `page_open` is 1, the page-open weight (address 0) is used. Otherwise the precharged-awake weight (address 1) is used.
- R3: When a rank's `cs` bit is 1, its 2-bit command code adds a command weight: code 1 adds the activate weight (address 3), code 2 the read weight (address 4), code 3 the write weight (address 5), and code 0 adds nothing. When `cs` is 0, no command weight is added, whatever the code.
- R4: When a rank's `odt` bit is 1, the termination weight (address 6) is added to that rank's input for the clock.
- R5: Each rank's input is the sum of its idle, command and termination weights, capped at 1023. Each accumulator is updated every clock as acc + input - (acc >> FILT_K). The accumulator never exceeds 1023 << FILT_K. `avg_out` field r (bits r*10 upward) equals acc >> FILT_K and shows the input presented before a clock edge just after that edge.
- R6: `throttle[r]` is registered at the same edge as the accumulator. After that edge it is 1 exactly when the new `avg_out` field r is greater than or equal to the threshold held before the edge.
- R7: A write (`wr_en` = 1) stores `wr_data[7:0]` into the weight at `wr_addr` 0 to 6. A write to address 7 stores `wr_data[9:0]` as the threshold. A written value is used from the next clock on.
- R8: A write to address 8 with `wr_data[0]` = 1 sets the lock. Once the lock is set, writes to addresses 0 to 6 are ignored, and writing 0 to address 8 does not clear it. Only reset clears the lock. The threshold stays writable while the lock is set.
- R9: The four ranks are independent. A rank's state, command and termination inputs affect only that rank's `avg_out` field and `throttle` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address (0-6 weights, 7 threshold, 8 lock) |
| wr_data | input | 10 | Write data |
| page_open | input | 4 | Per rank: at least one page is open |
| power_down | input | 4 | Per rank: rank is in power-down |
| cs | input | 4 | Per rank: a command is issued this clock |
| cmd_code | input | 8 | Per rank 2-bit command type, rank r at bits 2r+1:2r |
| odt | input | 4 | Per rank: on-die termination is active |
| avg_out | output | 40 | Per rank 10-bit filtered value, rank r at bits 10r+9:10r |
| throttle | output | 4 | Per rank throttle flag |

## Verification
The bench holds each rank in a fixed state for long enough that the filter settles. Rank 3 has both its page and power-down bits set, which separates the power-down override from the page-open choice. It then cycles through every command code with chip select high and low, so a command weight applied to the wrong code, or added without chip select, shows up as a different settled average. Termination is switched on one rank at a time, and long stretches of random per-rank activity then show whether inputs leak between ranks or the filter arithmetic drifts. Writes attempted after locking, a lock write of zero, threshold changes around the settled averages and a reset in the middle of activity test the lock, the throttle comparison edge and the reset state.

// File: rtl/rpf_pkg.sv
package rpf_pkg;
  localparam int ADDR_W      = 4;
  localparam int CMD_W       = 2;
  localparam int NUM_WEIGHTS = 7;

  typedef enum logic [ADDR_W-1:0] {
    A_IDLE_OPEN = 4'd0,
    A_IDLE_PRE  = 4'd1,
    A_IDLE_PD   = 4'd2,
    A_CMD_ACT   = 4'd3,
    A_CMD_RD    = 4'd4,
    A_CMD_WR    = 4'd5,
    A_ODT       = 4'd6,
    A_THRESH    = 4'd7,
    A_LOCK      = 4'd8
  } reg_addr_e;

  typedef enum logic [CMD_W-1:0] {
    CMD_NONE = 2'd0,
    CMD_ACT  = 2'd1,
    CMD_RD   = 2'd2,
    CMD_WR   = 2'd3
  } cmd_e;
endpackage

// File: rtl/rpf_weight_regs.sv
module rpf_weight_regs
  import rpf_pkg::*;
#(
  parameter int WEIGHT_W = 8,
  parameter int THR_W    = 10
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [THR_W-1:0]                wr_data,
  output logic [NUM_WEIGHTS*WEIGHT_W-1:0] weights_flat,
  output logic [THR_W-1:0]                thr_q,
  output logic                            locked
);
  localparam int IDX_W = $clog2(NUM_WEIGHTS);

  logic [WEIGHT_W-1:0] wt_q [NUM_WEIGHTS];
  logic                wt_hit;

  assign wt_hit = wr_en && !locked && (wr_addr < ADDR_W'(NUM_WEIGHTS));

  // weight table: one write port, indexed by address
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_WEIGHTS; i++) wt_q[i] <= '0;
    end else if (wt_hit) begin
      wt_q[wr_addr[IDX_W-1:0]] <= wr_data[WEIGHT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q  <= '0;
      locked <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_THRESH) thr_q <= wr_data;
      if (wr_en && wr_addr == A_LOCK && wr_data[0]) locked <= 1'b1;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_WEIGHTS; g++) begin : g_flat
      assign weights_flat[g*WEIGHT_W +: WEIGHT_W] = wt_q[g];
    end
  endgenerate
endmodule

// File: rtl/rpf_weight_sel.sv
module rpf_weight_sel
  import rpf_pkg::*;
#(
  parameter int WEIGHT_W = 8,
  parameter int SUM_W    = 10
) (
  input  logic                            page_open,
  input  logic                            power_down,
  input  logic                            cs,
  input  logic [CMD_W-1:0]                cmd_code,
  input  logic                            odt,
  input  logic [NUM_WEIGHTS*WEIGHT_W-1:0] weights_flat,
  output logic [SUM_W-1:0]                sum
);
  localparam int RAW_W   = ((WEIGHT_W + 2) > SUM_W ? (WEIGHT_W + 2) : SUM_W) + 1;
  localparam int SUM_MAX = (1 << SUM_W) - 1;
  localparam int O_OPEN  = int'(A_IDLE_OPEN) * WEIGHT_W;
  localparam int O_PRE   = int'(A_IDLE_PRE)  * WEIGHT_W;
  localparam int O_PD    = int'(A_IDLE_PD)   * WEIGHT_W;
  localparam int O_ACT   = int'(A_CMD_ACT)   * WEIGHT_W;
  localparam int O_RD    = int'(A_CMD_RD)    * WEIGHT_W;
  localparam int O_WR    = int'(A_CMD_WR)    * WEIGHT_W;
  localparam int O_ODT   = int'(A_ODT)       * WEIGHT_W;

  logic [WEIGHT_W-1:0] idle_w, cmd_w, odt_w;
  logic [RAW_W-1:0]    raw;

  always_comb begin
    if (power_down)     idle_w = weights_flat[O_PD   +: WEIGHT_W];
    else if (page_open) idle_w = weights_flat[O_OPEN +: WEIGHT_W];
    else                idle_w = weights_flat[O_PRE  +: WEIGHT_W];

    cmd_w = '0;
    if (cs) begin
      case (cmd_e'(cmd_code))
        CMD_ACT: cmd_w = weights_flat[O_ACT +: WEIGHT_W];
        CMD_RD:  cmd_w = weights_flat[O_RD  +: WEIGHT_W];
        CMD_WR:  cmd_w = weights_flat[O_WR  +: WEIGHT_W];
        default: cmd_w = '0;
      endcase
    end

    odt_w = odt ? weights_flat[O_ODT +: WEIGHT_W] : '0;

    raw = RAW_W'(idle_w) + RAW_W'(cmd_w) + RAW_W'(odt_w);
    if (raw > RAW_W'(SUM_MAX)) sum = SUM_W'(SUM_MAX);
    else                       sum = raw[SUM_W-1:0];
  end
endmodule

// File: rtl/rpf_ema_filter.sv
module rpf_ema_filter #(
  parameter int SUM_W  = 10,
  parameter int FILT_K = 4,
  parameter int ACC_W  = SUM_W + FILT_K + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SUM_W-1:0] in_sum,
  input  logic [SUM_W-1:0] thr,
  output logic [ACC_W-1:0] acc_q,
  output logic [SUM_W-1:0] avg,
  output logic             throttle
);
  logic [ACC_W-1:0] acc_next;
  logic [ACC_W-1:0] avg_next;

  assign acc_next = acc_q + ACC_W'(in_sum) - (acc_q >> FILT_K);
  assign avg_next = acc_next >> FILT_K;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      throttle <= 1'b0;
    end else begin
      acc_q    <= acc_next;
      throttle <= (avg_next >= ACC_W'(thr));
    end
  end

  assign avg = acc_q[FILT_K +: SUM_W];
endmodule

// File: rtl/rank_power_filter.sv
module rank_power_filter
  import rpf_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int WEIGHT_W  = 8,
  parameter int SUM_W     = 10,
  parameter int FILT_K    = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [SUM_W-1:0]           wr_data,
  input  logic [NUM_RANKS-1:0]       page_open,
  input  logic [NUM_RANKS-1:0]       power_down,
  input  logic [NUM_RANKS-1:0]       cs,
  input  logic [NUM_RANKS*CMD_W-1:0] cmd_code,
  input  logic [NUM_RANKS-1:0]       odt,
  output logic [NUM_RANKS*SUM_W-1:0] avg_out,
  output logic [NUM_RANKS-1:0]       throttle
);
  localparam int ACC_W = SUM_W + FILT_K + 1;

  logic [NUM_WEIGHTS*WEIGHT_W-1:0] weights_flat;
  logic [SUM_W-1:0]                thr_q;
  logic                            locked;
  logic [NUM_RANKS*ACC_W-1:0]      acc_flat;
  logic [NUM_RANKS*SUM_W-1:0]      sum_flat;

  rpf_weight_regs #(
    .WEIGHT_W (WEIGHT_W),
    .THR_W    (SUM_W)
  ) u_regs (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .weights_flat (weights_flat),
    .thr_q        (thr_q),
    .locked       (locked)
  );

  genvar r;
  generate
    for (r = 0; r < NUM_RANKS; r++) begin : g_rank
      rpf_weight_sel #(
        .WEIGHT_W (WEIGHT_W),
        .SUM_W    (SUM_W)
      ) u_sel (
        .page_open    (page_open[r]),
        .power_down   (power_down[r]),
        .cs           (cs[r]),
        .cmd_code     (cmd_code[r*CMD_W +: CMD_W]),
        .odt          (odt[r]),
        .weights_flat (weights_flat),
        .sum          (sum_flat[r*SUM_W +: SUM_W])
      );

      rpf_ema_filter #(
        .SUM_W  (SUM_W),
        .FILT_K (FILT_K),
        .ACC_W  (ACC_W)
      ) u_filt (
        .clk      (clk),
        .rst      (rst),
        .in_sum   (sum_flat[r*SUM_W +: SUM_W]),
        .thr      (thr_q),
        .acc_q    (acc_flat[r*ACC_W +: ACC_W]),
        .avg      (avg_out[r*SUM_W +: SUM_W]),
        .throttle (throttle[r])
      );
    end
  endgenerate
endmodule

// File: rtl/rpf_checker.sv
module rpf_checker
  import rpf_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int WEIGHT_W  = 8,
  parameter int SUM_W     = 10,
  parameter int FILT_K    = 4,
  parameter int ACC_W     = SUM_W + FILT_K + 1
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            locked,
  input logic [NUM_WEIGHTS*WEIGHT_W-1:0] weights_flat,
  input logic [SUM_W-1:0]                thr_q,
  input logic [NUM_RANKS*ACC_W-1:0]      acc_flat,
  input logic [NUM_RANKS*SUM_W-1:0]      avg_out,
  input logic [NUM_RANKS-1:0]            throttle
);
  localparam logic [ACC_W-1:0] ACC_MAX = ACC_W'(((1 << SUM_W) - 1) << FILT_K);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (avg_out == '0 && throttle == '0 && !locked && weights_flat == '0 && thr_q == '0));

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);

  assert_locked_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(weights_flat));

  genvar r;
  generate
    for (r = 0; r < NUM_RANKS; r++) begin : g_chk
      assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        acc_flat[r*ACC_W +: ACC_W] <= ACC_MAX);

      assert_throttle_cmp_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (throttle[r] == (avg_out[r*SUM_W +: SUM_W] >= $past(thr_q))));
    end
  endgenerate
endmodule

bind rank_power_filter rpf_checker #(
  .NUM_RANKS (NUM_RANKS),
  .WEIGHT_W  (WEIGHT_W),
  .SUM_W     (SUM_W),
  .FILT_K    (FILT_K),
  .ACC_W     (ACC_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .locked       (locked),
  .weights_flat (weights_flat),
  .thr_q        (thr_q),
  .acc_flat     (acc_flat),
  .avg_out      (avg_out),
  .throttle     (throttle)
);

// File: tb/tb_rank_power_filter.sv
`timescale 1ns/1ps
module tb_rank_power_filter;
  localparam int NR = 4;
  localparam int K  = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [9:0] wr_data = '0;
  logic [3:0] page_open = '0, power_down = '0, cs = '0, odt = '0;
  logic [7:0] cmd_code = '0;
  logic [39:0] avg_out;
  logic [3:0]  throttle;

  int vecs = 0;
  int errs = 0;

  // reference state
  int m_w[7];
  int m_thr, m_lock;
  int m_acc[NR];
  int m_thf[NR];

  always #4 clk = ~clk;

  rank_power_filter dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .page_open(page_open), .power_down(power_down), .cs(cs), .cmd_code(cmd_code),
    .odt(odt), .avg_out(avg_out), .throttle(throttle)
  );

  task automatic check(string tag, string what, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    for (int r = 0; r < NR; r++) begin
      check(tag, $sformatf("avg rank%0d", r), int'(avg_out[r*10 +: 10]), m_acc[r] >> K);
      check(tag, $sformatf("throttle rank%0d", r), int'(throttle[r]), m_thf[r]);
    end
  endtask

  // model of one clock edge, using the inputs currently driven
  task automatic model_edge();
    if (rst) begin
      for (int i = 0; i < 7; i++) m_w[i] = 0;
      m_thr = 0; m_lock = 0;
      for (int r = 0; r < NR; r++) begin m_acc[r] = 0; m_thf[r] = 0; end
      return;
    end
    for (int r = 0; r < NR; r++) begin
      int s, c, na;
      s = power_down[r] ? m_w[2] : (page_open[r] ? m_w[0] : m_w[1]);
      c = int'(cmd_code[r*2 +: 2]);
      if (cs[r] && c != 0) s += m_w[2 + c];
      if (odt[r]) s += m_w[6];
      if (s > 1023) s = 1023;
      na = m_acc[r] + s - (m_acc[r] >> K);
      m_thf[r] = ((na >> K) >= m_thr) ? 1 : 0;
      m_acc[r] = na;
    end
    if (wr_en) begin
      if (wr_addr < 7 && m_lock == 0) m_w[wr_addr] = int'(wr_data) & 255;
      if (wr_addr == 7) m_thr = int'(wr_data);
      if (wr_addr == 8 && wr_data[0]) m_lock = 1;
    end
  endtask

  task automatic tick(string tag);
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic run(string tag, int n);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic wr(string tag, int a, int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 10'(d);
    tick(tag);
    wr_en = 1'b0;
  endtask

  task automatic set_rank(int r, bit po, bit pd, bit c, int code, bit o);
    page_open[r] = po; power_down[r] = pd; cs[r] = c;
    cmd_code[r*2 +: 2] = 2'(code); odt[r] = o;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    run("R1 reset", 3);
    rst = 1'b0;
    compare_all("R1 reset outputs");
    run("R1 idle zero weights", 5);

    // R7: program weights and threshold
    wr("R7 write", 0, 40);
    wr("R7 write", 1, 20);
    wr("R7 write", 2, 5);
    wr("R7 write", 3, 60);
    wr("R7 write", 4, 30);
    wr("R7 write", 5, 35);
    wr("R7 write", 6, 12);
    wr("R7 write upper bits dropped", 6, 512 + 12);
    wr("R7 threshold", 7, 30);

    // R2: idle state selection, rank3 has both page and power-down set
    set_rank(0, 1, 0, 0, 0, 0);
    set_rank(1, 0, 0, 0, 0, 0);
    set_rank(2, 0, 1, 0, 0, 0);
    set_rank(3, 1, 1, 0, 0, 0);
    run("R2 idle select", 120);

    // R3: command codes with cs high and low
    for (int code = 0; code < 4; code++) begin
      for (int r = 0; r < NR; r++) set_rank(r, 0, 0, r[0], code, 0);
      run($sformatf("R3 cmd code %0d", code), 80);
    end

    // R4: termination weight on one rank at a time
    for (int r = 0; r < NR; r++) begin
      for (int q = 0; q < NR; q++) set_rank(q, 1, 0, 0, 0, q == r);
      run("R4 odt", 60);
    end

    // R6: threshold moved around settled averages
    wr("R6 threshold", 7, 52);
    run("R6 throttle", 10);
    wr("R6 threshold", 7, 53);
    run("R6 throttle", 10);
    wr("R6 threshold", 7, 0);
    run("R6 throttle zero", 5);
    wr("R6 threshold", 7, 1023);
    run("R6 throttle max", 5);

    // R9 / R5: random independent activity per rank
    wr("R9 threshold", 7, 45);
    for (int i = 0; i < 600; i++) begin
      for (int r = 0; r < NR; r++)
        set_rank(r, 1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 4), 1'($urandom));
      if (i % 100 == 0) begin
        wr_en = 1'b1; wr_addr = 4'($urandom % 7); wr_data = 10'($urandom);
      end
      tick("R9 R5 random");
      wr_en = 1'b0;
    end

    // R8: lock, then attempted writes
    for (int r = 0; r < NR; r++) set_rank(r, 1, 0, 0, 0, 0);
    wr("R8 set lock", 8, 1);
    wr("R8 locked write", 0, 200);
    wr("R8 lock zero", 8, 0);
    wr("R8 locked write", 0, 250);
    wr("R8 threshold while locked", 7, 10);
    run("R8 frozen weight", 80);

    // R1: reset mid-run clears lock; writes accepted again
    for (int r = 0; r < NR; r++) set_rank(r, $urandom % 2 == 1, 0, 1, 2, 1);
    rst = 1'b1;
    run("R1 mid reset", 2);
    rst = 1'b0;
    compare_all("R1 after reset");
    wr("R1 write after reset", 0, 100);
    wr("R1 write after reset", 4, 70);
    run("R1 relearn", 60);

    summary();
    $finish;
  end
endmodule